// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This block is the host side of a register-mapped firmware mailbox. It reaches the mailbox through a generic register port that carries an address, write data, read and write strobes, and read data with an acknowledge. When a command is accepted, the block protects the command identifier and the parameter length with a 6-bit CRC. It writes the length word and then the control word, and polls the control word until the firmware clears its busy bit. It then reads both words back, checks the CRC of the response, and reports a signed 11-bit result or an error code.

Firmware-reported CRC failures and CRC mismatches on the response set a sticky fault. The first time the fault sets, a one-cycle shutdown request is raised so that the host can stop traffic. The block can also run a plain software-reset write pair, which is not encoded and not polled.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, busy_o, done_o, fault_o, shutdown_o, bus_wr_o and bus_rd_o are 0. cmd_valid_i and swrst_i are accepted only while busy_o is 0. If both are high in the same idle cycle, cmd_valid_i wins. A request raised while busy_o is 1 causes no bus write.
- R2: The command encoding works as follows.
  - The CRC input is a preimage control word {1,1,1,id[12:0]} plus len[9:0].
  - Four bytes are fed through the CRC in this order: pre[7:0], pre[15:8], len[7:0], {6'b0,len[9:8]}.
  - Each byte is taken MSB first into a 6-bit register that starts at 0, with feedback polynomial 0x2F (x^6+x^5+x^3+x^2+x+1).
  - The length word is {1,1,crc[3:0],len}.
  - The control word is {1,crc[5:4],id}.
- R3: A command writes the length word to address 1 first and the control word to address 0 second. Read and write strobes are never high together, and each request holds until bus_ack_i.
- R4: After the control write, address 0 is read repeatedly while bit 15 reads 1. Consecutive polls are at least POLL_GAP cycles apart.
- R5: If busy is still set after POLL_LIMIT cycles of polling, the command ends with status 3 and result 0.
- R6: Once busy reads 0, address 0 is read and then address 1. The CRC is checked as follows.
  - The received CRC is {c[14:13], l[13:10]}.
  - It is compared with the CRC of control word c with bits 14 and 13 replaced by l[14] and l[15], together with l[9:0].
  - On a mismatch the status is 2 and the result is 0.
- R7: On a CRC match, result_o is the sign extension of {l[14], l[9:0]}. The status is 0 when that value is non-negative and 1 when it is negative.
- R8: fault_o sets when a command ends with status 2 or with result -1024 or -1023. It then stays set until fault_clr_i. If a set and a clear happen in the same cycle, the set wins.
- R9: shutdown_o pulses for exactly one cycle, in the cycle after done_o, and only when fault_o goes from 0 to 1.
- R10: A software reset writes 0 to address 1 and then 0x9907 to address 0. It does no reads, and ends with status 0 and result 0.
- R11: done_o is a one-cycle pulse, and busy_o stays high from the accepting edge through the done_o cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Start a command (idle only) |
| cmd_id_i | input | 13 | Command identifier |
| cmd_len_i | input | 10 | Parameter length in bytes |
| swrst_i | input | 1 | Start the software-reset write pair |
| fault_clr_i | input | 1 | Clear the sticky fault |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 firmware error, 2 CRC error, 3 timeout |
| result_o | output | 32 | Sign-extended firmware result |
| fault_o | output | 1 | Sticky CRC fault |
| shutdown_o | output | 1 | One-cycle shutdown request |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 16 | Write data |
| bus_wr_o | output | 1 | Write request |
| bus_rd_o | output | 1 | Read request |
| bus_rdata_i | input | 16 | Read data |
| bus_ack_i | input | 1 | Request complete |

## Verification
The bench builds the block with POLL_GAP of 4 and POLL_LIMIT of 60. With these values, a command that stays busy for several polls finishes within a few dozen cycles. A firmware model that never clears busy then reaches the timeout path in under a hundred cycles. The short gap also lets the bench measure the spacing between polls directly. The firmware model answers with CRC-encoded results that are valid, negative, at the range extremes, or deliberately corrupted, so every status code and both fault triggers are reached.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ID_W  = 13;
  localparam int LEN_W = 10;
  localparam int CRC_W = 6;
  localparam logic [CRC_W-1:0] CRC_POLY = 6'h2F;
  localparam logic [15:0] SWRST_WORD = 16'h9907;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_FW_ERR  = 2'd1,
    ST_CRC_ERR = 2'd2,
    ST_TIMEOUT = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WR_LEN, S_WR_CTRL, S_POLL_RD, S_POLL_WAIT, S_RD_CTRL, S_RD_LEN, S_FINISH
  } state_e;
endpackage

// File: rtl/mbox_crc6.sv
module mbox_crc6
  import mbox_pkg::*;
(
  input  logic [15:0]      word_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CRC_W-1:0] crc_o
);
  localparam int NB = 32;

  logic [NB-1:0] msg;
  logic [NB:0][CRC_W-1:0] chain;

  assign msg      = {{(16-LEN_W){1'b0}}, len_i, word_i};
  assign chain[0] = '0;

  // bytes low to high, each byte MSB first
  for (genvar k = 0; k < NB; k++) begin : g_bit
    localparam int SRC = (k / 8) * 8 + 7 - (k % 8);
    logic fb;
    assign fb         = chain[k][CRC_W-1] ^ msg[SRC];
    assign chain[k+1] = {chain[k][CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  assign crc_o = chain[NB];
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int GAP   = 1500,
  parameter int LIMIT = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  input  logic wait_i,
  output logic gap_done_o,
  output logic expired_o
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam int GW = $clog2(GAP + 1);

  logic [TW-1:0] tot_q;
  logic [GW-1:0] gap_q;

  assign expired_o  = tot_q >= TW'(LIMIT);
  assign gap_done_o = wait_i && (gap_q >= GW'(GAP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q <= '0;
      gap_q <= '0;
    end else begin
      if (clr_i)                  tot_q <= '0;
      else if (run_i && !expired_o) tot_q <= tot_q + 1'b1;
      gap_q <= wait_i ? gap_q + 1'b1 : '0;
    end
  end

  p_expire_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int CTRL_ADDR  = 0,
  parameter int LEN_ADDR   = 1,
  parameter int POLL_GAP   = 1500,
  parameter int POLL_LIMIT = 50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [ID_W-1:0]   cmd_id_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  input  logic              swrst_i,
  input  logic              fault_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [31:0]       result_o,
  output logic              fault_o,
  output logic              shutdown_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [15:0]       bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [15:0]       bus_rdata_i,
  input  logic              bus_ack_i
);
  localparam int RES_W = LEN_W + 1;
  localparam logic [RES_W-1:0] FW_CRC6_CODE  = {1'b1, {LEN_W{1'b0}}};
  localparam logic [RES_W-1:0] FW_CRC16_CODE = {1'b1, {(LEN_W-1){1'b0}}, 1'b1};

  state_e            state_q;
  logic [ID_W-1:0]   id_q;
  logic [LEN_W-1:0]  len_q;
  logic              swrst_q;
  logic [15:0]       ctrl_q;
  status_e           status_q;
  logic [31:0]       result_q;
  logic              fwcrc_q;
  logic              fault_q;
  logic              shut_q;

  // request encoding
  logic [CRC_W-1:0] enc_crc;
  logic [15:0]      ctrl_enc, len_enc;

  mbox_crc6 i_enc (
    .word_i ({3'b111, id_q}),
    .len_i  (len_q),
    .crc_o  (enc_crc)
  );

  assign ctrl_enc = {1'b1, enc_crc[5:4], id_q};
  assign len_enc  = {2'b11, enc_crc[3:0], len_q};

  // response check: ctrl_q holds control word, rdata holds length word
  logic [15:0]      ctrl_rec;
  logic [CRC_W-1:0] chk_crc, rx_crc;
  logic [RES_W-1:0] res_raw;
  logic             crc_ok;

  assign ctrl_rec = {ctrl_q[15], bus_rdata_i[14], bus_rdata_i[15], ctrl_q[12:0]};
  assign rx_crc   = {ctrl_q[14:13], bus_rdata_i[13:10]};
  assign res_raw  = {bus_rdata_i[14], bus_rdata_i[LEN_W-1:0]};

  mbox_crc6 i_chk (
    .word_i (ctrl_rec),
    .len_i  (bus_rdata_i[LEN_W-1:0]),
    .crc_o  (chk_crc)
  );

  assign crc_ok = chk_crc == rx_crc;

  // poll timing
  logic gap_done, expired;

  mbox_poll_timer #(
    .GAP   (POLL_GAP),
    .LIMIT (POLL_LIMIT)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state_q == S_WR_CTRL),
    .run_i      (state_q == S_POLL_RD || state_q == S_POLL_WAIT),
    .wait_i     (state_q == S_POLL_WAIT),
    .gap_done_o (gap_done),
    .expired_o  (expired)
  );

  always_comb begin
    bus_wr_o    = 1'b0;
    bus_rd_o    = 1'b0;
    bus_addr_o  = ADDR_W'(CTRL_ADDR);
    bus_wdata_o = '0;
    unique case (state_q)
      S_WR_LEN: begin
        bus_wr_o    = 1'b1;
        bus_addr_o  = ADDR_W'(LEN_ADDR);
        bus_wdata_o = swrst_q ? 16'h0000 : len_enc;
      end
      S_WR_CTRL: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = swrst_q ? SWRST_WORD : ctrl_enc;
      end
      S_POLL_RD, S_RD_CTRL: bus_rd_o = 1'b1;
      S_RD_LEN: begin
        bus_rd_o   = 1'b1;
        bus_addr_o = ADDR_W'(LEN_ADDR);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      id_q     <= '0;
      len_q    <= '0;
      swrst_q  <= 1'b0;
      ctrl_q   <= '0;
      status_q <= ST_OK;
      result_q <= '0;
      fwcrc_q  <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_valid_i) begin
            id_q    <= cmd_id_i;
            len_q   <= cmd_len_i;
            swrst_q <= 1'b0;
            state_q <= S_WR_LEN;
          end else if (swrst_i) begin
            swrst_q <= 1'b1;
            state_q <= S_WR_LEN;
          end
        end
        S_WR_LEN: if (bus_ack_i) state_q <= S_WR_CTRL;
        S_WR_CTRL: begin
          if (bus_ack_i) begin
            if (swrst_q) begin
              status_q <= ST_OK;
              result_q <= '0;
              fwcrc_q  <= 1'b0;
              state_q  <= S_FINISH;
            end else begin
              state_q <= S_POLL_RD;
            end
          end
        end
        S_POLL_RD: if (bus_ack_i) state_q <= bus_rdata_i[15] ? S_POLL_WAIT : S_RD_CTRL;
        S_POLL_WAIT: begin
          if (expired) begin
            status_q <= ST_TIMEOUT;
            result_q <= '0;
            fwcrc_q  <= 1'b0;
            state_q  <= S_FINISH;
          end else if (gap_done) begin
            state_q <= S_POLL_RD;
          end
        end
        S_RD_CTRL: begin
          if (bus_ack_i) begin
            ctrl_q  <= bus_rdata_i;
            state_q <= S_RD_LEN;
          end
        end
        S_RD_LEN: begin
          if (bus_ack_i) begin
            if (!crc_ok) begin
              status_q <= ST_CRC_ERR;
              result_q <= '0;
              fwcrc_q  <= 1'b1;
            end else begin
              status_q <= res_raw[RES_W-1] ? ST_FW_ERR : ST_OK;
              result_q <= {{(32-RES_W){res_raw[RES_W-1]}}, res_raw};
              fwcrc_q  <= (res_raw == FW_CRC6_CODE) || (res_raw == FW_CRC16_CODE);
            end
            state_q <= S_FINISH;
          end
        end
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // sticky fault; a new hit outranks a clear
  logic fault_hit;
  assign fault_hit = (state_q == S_FINISH) && fwcrc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      shut_q  <= 1'b0;
    end else begin
      fault_q <= fault_hit | (fault_q & ~fault_clr_i);
      shut_q  <= fault_hit & ~fault_q;
    end
  end

  assign busy_o     = state_q != S_IDLE;
  assign done_o     = state_q == S_FINISH;
  assign status_o   = status_q;
  assign result_o   = result_q;
  assign fault_o    = fault_q;
  assign shutdown_o = shut_q;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!bus_wr_o && !bus_rd_o));
  p_bus_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o && !bus_ack_i) |=> (bus_rd_o && $stable(bus_addr_o)));
  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);
  p_shut_edge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> (fault_o && !$past(fault_o) && $past(done_o)));
  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

// File: tb/test_mbox_cmd_seq.sv
module test_mbox_cmd_seq;
  localparam int GAP   = 4;
  localparam int LIMIT = 60;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [12:0] cmd_id = 0;
  logic [9:0]  cmd_len = 0;
  logic        swrst = 0;
  logic        fclr = 0;
  logic        busy, done, fault, shut, bwr, brd;
  logic [1:0]  status;
  logic [31:0] result;
  logic [4:0]  baddr;
  logic [15:0] bwdata;
  logic [15:0] brdata = 0;
  logic        back = 0;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  mbox_cmd_seq #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) i_mbox_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_id_i(cmd_id),
    .cmd_len_i(cmd_len), .swrst_i(swrst), .fault_clr_i(fclr), .busy_o(busy),
    .done_o(done), .status_o(status), .result_o(result), .fault_o(fault),
    .shutdown_o(shut), .bus_addr_o(baddr), .bus_wdata_o(bwdata), .bus_wr_o(bwr),
    .bus_rd_o(brd), .bus_rdata_i(brdata), .bus_ack_i(back)
  );

  always #5 clk = ~clk;

  // reference CRC via byte table
  logic [5:0] ctab [256];
  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [7:0] r;
      r = 8'(i);
      for (int b = 0; b < 8; b++) r = r[7] ? ((r << 1) ^ 8'hBC) : (r << 1);
      ctab[i] = r[7:2];
    end
  end

  function automatic logic [5:0] ref_crc(input logic [15:0] w, input logic [9:0] l);
    logic [31:0] d;
    logic [5:0]  c;
    d = {6'b0, l, w};
    c = 0;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] x;
      x = {c, 2'b00} ^ d[8*i +: 8];
      c = ctab[x];
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // firmware model
  int         fw_busy_left = 0;
  bit         fw_hang = 0;
  logic [15:0] fw_ctrl = 0, fw_len = 0;
  int         wa[$];
  int         wd[$];
  int         ra[$];
  int         rt[$];

  initial begin
    forever begin
      @(negedge clk);
      if (back) back = 0;
      else if (bwr) begin
        wa.push_back(int'(baddr));
        wd.push_back(int'(bwdata));
        back = 1;
      end else if (brd) begin
        ra.push_back(int'(baddr));
        rt.push_back(cyc);
        if (baddr == 0) begin
          if (fw_hang || fw_busy_left > 0) begin
            brdata = 16'h8000;
            if (fw_busy_left > 0) fw_busy_left--;
          end else brdata = fw_ctrl;
        end else brdata = fw_len;
        back = 1;
      end
    end
  end

  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // per-clock protocol comparison
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (bwr && brd) chk(0, "R3 strobes overlap", 1, 0);
      if (!busy && (bwr || brd)) chk(0, "R1 request while idle", 1, 0);
      if ((bwr || brd) && baddr > 1) chk(0, "R3 address", baddr, 1);
    end
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic set_resp(input logic [12:0] id, input int v, input bit corrupt);
    logic [10:0] r;
    logic [5:0]  c;
    r = 11'(v);
    c = ref_crc({1'b0, r[10], 1'b1, id}, r[9:0]);
    fw_ctrl = {1'b0, c[5:4], id};
    fw_len  = {1'b1, r[10], c[3:0], r[9:0]};
    if (corrupt) fw_len[0] = ~fw_len[0];
  endtask

  task automatic wait_done(output bit seen, input bit poke);
    seen = 0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (poke && n == 3) begin
        cmd_valid = 1; cmd_id = 13'h0AAA; swrst = 1;
      end else if (poke && n == 4) begin
        cmd_valid = 0; swrst = 0;
      end
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic run_cmd(input logic [12:0] id, input logic [9:0] len, input int v,
                         input bit corrupt, input int polls, input bit hang,
                         input int est, input int eres, input bit efault,
                         input bit eshut, input bit poke, input bit hold_clr);
    bit seen;
    logic [5:0] c;
    wa.delete(); wd.delete(); ra.delete(); rt.delete();
    fw_busy_left = polls;
    fw_hang = hang;
    set_resp(id, v, corrupt);
    @(negedge clk);
    cmd_id = id; cmd_len = len; cmd_valid = 1; fclr = hold_clr;
    @(negedge clk);
    cmd_valid = 0;
    chk(busy == 1, "R11 busy after accept", busy, 1);
    wait_done(seen, poke);
    chk(seen, "R11 done seen", seen, 1);
    chk(busy == 1, "R11 busy during done", busy, 1);
    chk(status == 2'(est), (est == 3) ? "R5 timeout status" : (est == 2) ? "R6 status" : "R7 status", status, est);
    chk(result == 32'(eres), "R7 result", $signed(result), eres);
    c = ref_crc({3'b111, id}, len);
    chk(wa.size() == 2, "R1 R3 write count", wa.size(), 2);
    if (wa.size() == 2) begin
      chk(wa[0] == 1 && wa[1] == 0, "R3 write order", wa[0], 1);
      chk(wd[0] == int'({2'b11, c[3:0], len}), "R2 length word", wd[0], int'({2'b11, c[3:0], len}));
      chk(wd[1] == int'({1'b1, c[5:4], id}), "R2 control word", wd[1], int'({1'b1, c[5:4], id}));
    end
    if (!hang) begin
      chk(ra.size() == polls + 3, "R4 read count", ra.size(), polls + 3);
      if (ra.size() >= 2)
        chk(ra[ra.size()-2] == 0 && ra[ra.size()-1] == 1, "R6 readback order", ra[ra.size()-1], 1);
    end else begin
      chk(ra.size() >= 2, "R5 polled before timeout", ra.size(), 2);
    end
    for (int i = 1; i + 2 < ra.size() || (hang && i < ra.size()); i++)
      chk(rt[i] - rt[i-1] >= GAP, "R4 poll spacing", rt[i] - rt[i-1], GAP);
    @(negedge clk);
    fclr = 0;
    chk(done == 0, "R11 done one cycle", done, 0);
    chk(shut == eshut, "R9 shutdown pulse", shut, eshut);
    chk(fault == efault, "R8 fault flag", fault, efault);
    @(negedge clk);
    chk(shut == 0, "R9 shutdown one cycle", shut, 0);
    chk(busy == 0, "R11 idle after done", busy, 0);
  endtask

  task automatic clear_fault();
    @(negedge clk);
    fclr = 1;
    @(negedge clk);
    fclr = 0;
    chk(fault == 0, "R8 clear", fault, 0);
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    chk(fault == 0 && shut == 0, "R1 reset fault", {fault, shut}, 0);
    chk(bwr == 0 && brd == 0, "R1 reset bus", {bwr, brd}, 0);
    rst_n = 1;
    @(negedge clk);

    run_cmd(13'h0123, 10'd40,    5, 0, 0, 0, 0,     5, 0, 0, 0, 0);
    run_cmd(13'h1FFF, 10'h3FF, 1023, 0, 3, 0, 0,  1023, 0, 0, 0, 0);
    run_cmd(13'h0042, 10'd0,    -7, 0, 1, 0, 1,    -7, 0, 0, 0, 0);
    run_cmd(13'h0055, 10'd12,    3, 1, 0, 0, 2,     0, 1, 1, 0, 0);
    run_cmd(13'h0056, 10'd8, -1024, 0, 0, 0, 1, -1024, 1, 0, 0, 0);
    clear_fault();
    run_cmd(13'h0057, 10'd8, -1023, 0, 2, 0, 1, -1023, 1, 1, 0, 0);
    clear_fault();
    run_cmd(13'h0100, 10'd2,     0, 0, 0, 1, 3,     0, 0, 0, 0, 0);
    // requests while busy are ignored (R1)
    run_cmd(13'h0301, 10'd20,   17, 0, 5, 0, 0,    17, 0, 0, 1, 0);
    // set wins over a held clear (R8)
    run_cmd(13'h0302, 10'd4,     9, 1, 0, 0, 2,     0, 1, 1, 0, 1);
    clear_fault();

    // software reset (R10)
    wa.delete(); wd.delete(); ra.delete();
    @(negedge clk);
    swrst = 1;
    @(negedge clk);
    swrst = 0;
    wait_done(seen, 0);
    chk(seen, "R10 done", seen, 1);
    chk(status == 0 && result == 0, "R10 status", status, 0);
    chk(wa.size() == 2, "R10 write count", wa.size(), 2);
    if (wa.size() == 2) begin
      chk(wa[0] == 1 && wd[0] == 0, "R10 first write", wd[0], 0);
      chk(wa[1] == 0 && wd[1] == 16'h9907, "R10 second write", wd[1], 16'h9907);
    end
    chk(ra.size() == 0, "R10 no reads", ra.size(), 0);

    // start wins over reset in the same idle cycle (R1)
    wa.delete(); wd.delete(); ra.delete();
    fw_busy_left = 0; fw_hang = 0;
    set_resp(13'h0007, 1, 0);
    @(negedge clk);
    cmd_id = 13'h0007; cmd_len = 10'd6; cmd_valid = 1; swrst = 1;
    @(negedge clk);
    cmd_valid = 0; swrst = 0;
    wait_done(seen, 0);
    chk(status == 0 && result == 1, "R1 start priority result", result, 1);
    chk(wa.size() == 2 && wd[1] != 16'h9907, "R1 start priority writes", wa.size(), 2);
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule